// File: doc/BRIEF.md
# Multidrop Serial Receive Channel

This block is one receive channel of an asynchronous serial port. It watches a serial line sampled at sixteen times the bit rate, finds each start bit, checks it at mid-bit, and shifts in the data bits least significant bit first. It then reads an optional tag bit and one stop bit. Each finished character goes into a small receive queue, three entries deep by default. An entry holds the data byte and three flags: break, framing error, and parity error (or address tag). The CPU reads the oldest entry through a read strobe. A ready output shows that unread entries are present.

The queue uses plain read and write pointers. A receiver reset only moves both pointers back to entry zero. It clears the flags of that entry but leaves the stored data bytes in place. A read made while the queue is empty still moves the read pointer on, so the output shows old data until the next reset. In multidrop mode the channel keeps watching the line even while disabled. In that state it stores only characters whose tag bit marks them as addresses. The received tag bit is always placed in the parity flag position.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After power-up reset, `rx_rdy` is 0, `rx_status` is 0 and `rx_data` is 0. The receiver starts disabled.
- R2: When enabled, a frame is received and stored in the queue: a low start bit, DATA_BITS data bits least significant bit first, a tag bit unless `cfg_pmode` = 2'b10, and a stop bit. `rx_rdy` then rises and `rx_data` shows the oldest unread byte. Each `cpu_rd` pulse retires one entry.
- R3: A falling edge on the line is checked again at the 8th sample of 16. If the line is high by then, the receiver returns to hunting and stores nothing.
- R4: `rx_status` is laid out as {break, framing, parity/tag, overrun}, bits [3:0]. `cfg_pmode` selects the parity flag: 2'b00 flags `tag ^ (^data) ^ cfg_odd`; 2'b01 flags `tag != cfg_odd`; 2'b10 means no tag bit and the flag stays 0.
- R5: A stop bit sampled low sets the framing flag. If the data bits and the tag bit are also all zero, the break flag is set as well. After a break, no new start bit is looked for until the line has gone high.
- R6: Outside multidrop mode, a disabled receiver ignores the line. `cmd_disable` drops any partly assembled character at once but keeps the queued entries readable. After `cmd_enable`, assembly starts at the next start bit.
- R7: If a character completes while all entries are unread, it overwrites the most recently written entry. The overrun bit (`rx_status[0]`) then stays set until a receiver reset.
- R8: `cmd_reset` drops the character in assembly, clears `rx_rdy` and the overrun bit, and puts both pointers back to entry 0. It also clears the flags of entry 0 but keeps every stored data byte.
- R9: A `cpu_rd` with no unread entry still moves the read pointer on. Later reads then show entries that were already read, until a reset puts the pointers back in line.
- R10: With `cfg_pmode` = 2'b11 and the receiver disabled, a character with tag 1 is stored and raises `rx_rdy`. A character with tag 0 is dropped.
- R11: With `cfg_pmode` = 2'b11 and the receiver enabled, every character is stored. The received tag bit appears in the parity/tag flag, `rx_status[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| rxd | input | 1 | Serial line, idle high |
| sample_en | input | 1 | One pulse per oversampling tick (16 per bit) |
| cmd_enable | input | 1 | Enable strobe |
| cmd_disable | input | 1 | Disable strobe, wins over enable |
| cmd_reset | input | 1 | Receiver reset strobe |
| cfg_pmode | input | 2 | 00 parity, 01 forced parity, 10 none, 11 multidrop |
| cfg_odd | input | 1 | Odd parity or forced level |
| cpu_rd | input | 1 | Read strobe that retires the head entry |
| rx_rdy | output | 1 | Unread entries present |
| rx_data | output | DATA_BITS | Data byte at the read pointer |
| rx_status | output | 4 | {break, framing, parity/tag, overrun} |

## Verification
The properties assume that the command strobes and `cpu_rd` last one clock each. They also assume that `cfg_pmode` and `cfg_odd` only change while no frame is on the line. Otherwise a frame could finish under a different filter than the one it began under. The bench changes the mode only between frames, after a long idle stretch with the line high. It gives every strobe exactly one cycle at a falling clock edge. The only command it places inside a frame is the deliberate disable.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_TAG,
      S_STOP,
      S_BRKW
   } rx_state_e;

   typedef struct packed {
      logic brk;
      logic fe;
      logic pe;
   } rx_flags_t;

   localparam int FLAG_W = 3;

   localparam logic [1:0] PM_PAR   = 2'b00;
   localparam logic [1:0] PM_FORCE = 2'b01;
   localparam logic [1:0] PM_NONE  = 2'b10;
   localparam logic [1:0] PM_MDROP = 2'b11;

endpackage

// File: rtl/mdrx_shifter.sv
module mdrx_shifter
   import mdrx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int OSR       = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rxd,
   input  logic                 sample_en,
   input  logic                 run,
   input  logic                 flush,
   input  logic [1:0]           pmode,
   input  logic                 odd,
   output logic                 chr_valid,
   output logic [DATA_BITS-1:0] chr_data,
   output rx_flags_t            chr_flags,
   output logic                 chr_tag
);

   localparam int TW = $clog2(OSR);
   localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam logic [TW-1:0] T_LAST = TW'(OSR - 1);
   localparam logic [TW-1:0] T_MID  = TW'(OSR / 2 - 2);
   localparam logic [BW-1:0] B_LAST = BW'(DATA_BITS - 1);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("mdrx_shifter: OSR must be even and at least 4");
      end
   endgenerate

   rx_state_e            state_q;
   logic [TW-1:0]        tick_q;
   logic [BW-1:0]        bit_q;
   logic [DATA_BITS-1:0] sh_q;
   logic                 tag_q;
   logic                 has_tag;
   logic                 pe_c;
   logic                 brk_c;

   assign has_tag = (pmode != PM_NONE);
   assign brk_c   = (sh_q == '0) && !tag_q && !rxd;

   always_comb begin
      unique case (pmode)
         PM_PAR:   pe_c = tag_q ^ (^sh_q) ^ odd;
         PM_FORCE: pe_c = tag_q ^ odd;
         PM_NONE:  pe_c = 1'b0;
         default:  pe_c = tag_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         tick_q    <= '0;
         bit_q     <= '0;
         sh_q      <= '0;
         tag_q     <= 1'b0;
         chr_valid <= 1'b0;
         chr_data  <= '0;
         chr_flags <= '0;
         chr_tag   <= 1'b0;
      end else begin
         chr_valid <= 1'b0;
         if (flush || !run) begin
            state_q <= S_IDLE;
         end else if (sample_en) begin
            unique case (state_q)
               S_IDLE: begin
                  if (!rxd) begin
                     state_q <= S_START;
                     tick_q  <= '0;
                     tag_q   <= 1'b0;
                  end
               end
               S_START: begin
                  if (tick_q == T_MID) begin
                     tick_q  <= '0;
                     bit_q   <= '0;
                     state_q <= rxd ? S_IDLE : S_DATA;
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
               S_DATA: begin
                  if (tick_q == T_LAST) begin
                     tick_q <= '0;
                     sh_q   <= {rxd, sh_q[DATA_BITS-1:1]};
                     if (bit_q == B_LAST) begin
                        state_q <= has_tag ? S_TAG : S_STOP;
                     end else begin
                        bit_q <= bit_q + 1'b1;
                     end
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
               S_TAG: begin
                  if (tick_q == T_LAST) begin
                     tick_q  <= '0;
                     tag_q   <= rxd;
                     state_q <= S_STOP;
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
               S_STOP: begin
                  if (tick_q == T_LAST) begin
                     tick_q    <= '0;
                     chr_valid <= 1'b1;
                     chr_data  <= sh_q;
                     chr_tag   <= tag_q;
                     chr_flags <= '{brk: brk_c, fe: !rxd, pe: pe_c};
                     state_q   <= brk_c ? S_BRKW : S_IDLE;
                  end else begin
                     tick_q <= tick_q + 1'b1;
                  end
               end
               S_BRKW: begin
                  if (rxd) state_q <= S_IDLE;
               end
               default: state_q <= S_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/mdrx_fifo.sv
module mdrx_fifo #(
   parameter int W      = 11,
   parameter int FLAG_W = 3,
   parameter int DEPTH  = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   input  logic         realign,
   output logic [W-1:0] rdata,
   output logic         nonempty,
   output logic         ovr
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mdrx_fifo: DEPTH must be at least 2");
      end
      if (FLAG_W >= W) begin : g_bad_flag
         $error("mdrx_fifo: FLAG_W must be narrower than W");
      end
   endgenerate

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] rd_q, wr_q, widx;
   logic [CW-1:0] cnt_q;
   logic          full, wr_ok, ovw, push, pop;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == P_LAST) ? '0 : p + 1'b1;
   endfunction

   assign full  = (cnt_q == C_FULL);
   assign wr_ok = wr && !realign;
   assign ovw   = wr_ok && full && !rd;
   assign push  = wr_ok && !ovw;
   assign pop   = rd && (cnt_q != '0);
   assign widx  = ovw ? ((wr_q == '0) ? P_LAST : wr_q - 1'b1) : wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (realign && e == 0) begin
               mem_q[e][W-1 -: FLAG_W] <= '0;
            end else if (wr_ok && widx == PW'(e)) begin
               mem_q[e] <= wdata;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
         ovr   <= 1'b0;
      end else if (realign) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
         ovr   <= 1'b0;
      end else begin
         if (push) wr_q <= step(wr_q);
         if (rd)   rd_q <= step(rd_q);
         unique case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (ovw) ovr <= 1'b1;
      end
   end

   assign rdata    = mem_q[rd_q];
   assign nonempty = (cnt_q != '0);

endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
   import mdrx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int OSR       = 16,
   parameter int DEPTH     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rxd,
   input  logic                 sample_en,
   input  logic                 cmd_enable,
   input  logic                 cmd_disable,
   input  logic                 cmd_reset,
   input  logic [1:0]           cfg_pmode,
   input  logic                 cfg_odd,
   input  logic                 cpu_rd,
   output logic                 rx_rdy,
   output logic [DATA_BITS-1:0] rx_data,
   output logic [3:0]           rx_status
);

   localparam int EW = DATA_BITS + FLAG_W;

   generate
      if (DATA_BITS < 5 || DATA_BITS > 8) begin : g_bad_bits
         $error("mdrop_uart_rx: DATA_BITS must be 5 to 8");
      end
   endgenerate

   logic                 rx_en_q;
   logic                 mdrop;
   logic                 run;
   logic                 chr_valid;
   logic [DATA_BITS-1:0] chr_data;
   rx_flags_t            chr_flags;
   logic                 chr_tag;
   logic                 fifo_wr;
   logic [EW-1:0]        head;
   logic                 ovr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rx_en_q <= 1'b0;
      else if (cmd_disable) rx_en_q <= 1'b0;
      else if (cmd_enable)  rx_en_q <= 1'b1;
   end

   assign mdrop   = (cfg_pmode == PM_MDROP);
   assign run     = rx_en_q || mdrop;
   assign fifo_wr = chr_valid && (rx_en_q || (mdrop && chr_tag));

   mdrx_shifter #(
      .DATA_BITS (DATA_BITS),
      .OSR       (OSR)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .rxd       (rxd),
      .sample_en (sample_en),
      .run       (run),
      .flush     (cmd_reset),
      .pmode     (cfg_pmode),
      .odd       (cfg_odd),
      .chr_valid (chr_valid),
      .chr_data  (chr_data),
      .chr_flags (chr_flags),
      .chr_tag   (chr_tag)
   );

   mdrx_fifo #(
      .W      (EW),
      .FLAG_W (FLAG_W),
      .DEPTH  (DEPTH)
   ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (fifo_wr),
      .wdata    ({chr_flags, chr_data}),
      .rd       (cpu_rd),
      .realign  (cmd_reset),
      .rdata    (head),
      .nonempty (rx_rdy),
      .ovr      (ovr)
   );

   assign rx_data   = head[DATA_BITS-1:0];
   assign rx_status = {head[EW-1 -: FLAG_W], ovr};

endmodule

// File: rtl/mdrop_uart_rx_chk.sv
module mdrop_uart_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_rd,
   input logic       cmd_reset,
   input logic       rx_rdy,
   input logic [3:0] rx_status,
   input logic       fifo_wr,
   input logic       rx_en_q,
   input logic       mdrop,
   input logic       chr_tag
);

   // R8
   reset_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (!rx_rdy && rx_status == 4'b0000));

   // R2
   rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_rdy) |-> $past(cpu_rd || cmd_reset));

   // R2
   rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_rdy) |-> $past(fifo_wr));

   // R10
   store_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> (rx_en_q || (mdrop && chr_tag)));

   // R7
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_status[0]) |-> $past(rx_rdy && fifo_wr));

   // R5
   break_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_status[3] |-> rx_status[2]);

endmodule

bind mdrop_uart_rx mdrop_uart_rx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_rd    (cpu_rd),
   .cmd_reset (cmd_reset),
   .rx_rdy    (rx_rdy),
   .rx_status (rx_status),
   .fifo_wr   (fifo_wr),
   .rx_en_q   (rx_en_q),
   .mdrop     (mdrop),
   .chr_tag   (chr_tag)
);

// File: tb/mdrop_uart_rx_bench.sv
module mdrop_uart_rx_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       sample_en = 1'b0;
   logic       cmd_enable = 1'b0;
   logic       cmd_disable = 1'b0;
   logic       cmd_reset = 1'b0;
   logic [1:0] cfg_pmode = 2'b10;
   logic       cfg_odd = 1'b0;
   logic       cpu_rd = 1'b0;
   logic       rx_rdy;
   logic [7:0] rx_data;
   logic [3:0] rx_status;

   int    vectors = 0;
   int    errors = 0;
   bit    settled = 0;
   string cur_req = "R1";

   // behavioural model of the queue
   logic [7:0] m_d [3];
   logic [2:0] m_f [3];
   int m_rd = 0, m_wr = 0, m_cnt = 0;
   bit m_ovr = 0, m_en = 0;

   always #5 clk = ~clk;
   always @(negedge clk) sample_en <= ~sample_en;

   mdrop_uart_rx u_mdrop_uart_rx (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .sample_en(sample_en),
      .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
      .cfg_pmode(cfg_pmode), .cfg_odd(cfg_odd), .cpu_rd(cpu_rd),
      .rx_rdy(rx_rdy), .rx_data(rx_data), .rx_status(rx_status)
   );

   always begin
      @(posedge clk);
      #3;
      if (settled) begin
         vectors++;
         if (rx_rdy !== (m_cnt != 0) || rx_data !== m_d[m_rd] ||
             rx_status !== {m_f[m_rd], m_ovr}) begin
            errors++;
            $display("FAIL %s: rdy/data/status got %b/%h/%b exp %b/%h/%b", cur_req,
                     rx_rdy, rx_data, rx_status, (m_cnt != 0), m_d[m_rd], {m_f[m_rd], m_ovr});
         end
      end
   end

   task automatic lit(input string req, input logic [7:0] got, input logic [7:0] exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h exp %h", req, got, exp);
      end
   endtask

   function automatic logic pe_rule(input logic [7:0] d, input logic t);
      case (cfg_pmode)
         2'b00:   return t ^ (^d) ^ cfg_odd;
         2'b01:   return t ^ cfg_odd;
         2'b10:   return 1'b0;
         default: return t;
      endcase
   endfunction

   task automatic m_push(input logic [7:0] d, input logic [2:0] f);
      if (m_cnt == 3) begin
         m_d[(m_wr + 2) % 3] = d;
         m_f[(m_wr + 2) % 3] = f;
         m_ovr = 1;
      end else begin
         m_d[m_wr] = d;
         m_f[m_wr] = f;
         m_wr = (m_wr + 1) % 3;
         m_cnt++;
      end
   endtask

   task automatic rd_pulse();
      @(negedge clk);
      cpu_rd = 1'b1;
      if (m_cnt > 0) m_cnt--;
      m_rd = (m_rd + 1) % 3;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic cmd(input int which);
      @(negedge clk);
      case (which)
         0: begin cmd_enable = 1'b1; m_en = 1; end
         1: begin cmd_disable = 1'b1; m_en = 0; end
         default: begin
            cmd_reset = 1'b1;
            m_rd = 0; m_wr = 0; m_cnt = 0; m_ovr = 0; m_f[0] = 3'b000;
         end
      endcase
      @(negedge clk);
      cmd_enable = 1'b0; cmd_disable = 1'b0; cmd_reset = 1'b0;
   endtask

   // frame: start, 8 data LSB first, tag unless mode 10, stop
   task automatic send(input logic [7:0] d, input logic t, input logic stp,
                       input int stop_cyc, input int extra_low, input int dis_at);
      logic fr [11];
      int   n;
      int   len;
      logic brk;
      settled = 0;
      n = 0;
      fr[n] = 1'b0; n++;
      for (int i = 0; i < 8; i++) begin fr[n] = d[i]; n++; end
      if (cfg_pmode != 2'b10) begin fr[n] = t; n++; end
      fr[n] = stp; n++;
      for (int i = 0; i < n; i++) begin
         len = (i == n - 1) ? stop_cyc : 32;
         for (int c = 0; c < len; c++) begin
            @(negedge clk);
            rxd = fr[i];
            cmd_disable = (i == dis_at && c == 0);
         end
      end
      repeat (extra_low) @(negedge clk);
      @(negedge clk);
      rxd = 1'b1;
      cmd_disable = 1'b0;
      repeat (40) @(negedge clk);
      if (dis_at >= 0) m_en = 0;
      brk = (d == 8'h00) && !(cfg_pmode != 2'b10 && t) && !stp;
      if (dis_at < 0 && (m_en || (cfg_pmode == 2'b11 && t)))
         m_push(d, {brk, !stp, pe_rule(d, (cfg_pmode == 2'b10) ? 1'b0 : t)});
      settled = 1;
   endtask

   task automatic frame(input logic [7:0] d, input logic t);
      send(d, t, 1'b1, 32, 0, -1);
   endtask

   initial begin
      for (int i = 0; i < 3; i++) begin m_d[i] = 8'h00; m_f[i] = 3'b000; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      settled = 1;
      repeat (3) @(negedge clk);
      // R1 reset state
      lit("R1", {7'b0, rx_rdy}, 8'h00);
      lit("R1", {4'b0, rx_status}, 8'h00);

      // R6 disabled receiver ignores the line
      cur_req = "R6";
      frame(8'h5A, 1'b0);
      lit("R6", {7'b0, rx_rdy}, 8'h00);

      // R2 basic receive
      cur_req = "R2";
      cmd(0);
      frame(8'hA5, 1'b0);
      lit("R2", rx_data, 8'hA5);
      lit("R2", {7'b0, rx_rdy}, 8'h01);
      rd_pulse();

      // R3 false start then valid character
      cur_req = "R3";
      settled = 0;
      @(negedge clk); rxd = 1'b0;
      repeat (6) @(negedge clk);
      rxd = 1'b1;
      repeat (60) @(negedge clk);
      settled = 1;
      lit("R3", {7'b0, rx_rdy}, 8'h00);
      frame(8'h3C, 1'b0);
      rd_pulse();

      // R4 parity modes
      cur_req = "R4";
      cfg_pmode = 2'b00; cfg_odd = 1'b0;
      frame(8'h07, 1'b1);
      lit("R4", {4'b0, rx_status}, 8'h00);
      rd_pulse();
      frame(8'h07, 1'b0);
      lit("R4", {4'b0, rx_status}, 8'h02);
      rd_pulse();
      cfg_odd = 1'b1;
      frame(8'h07, 1'b0);
      frame(8'h81, 1'b0);
      rd_pulse(); rd_pulse();
      cfg_pmode = 2'b01;
      frame(8'h12, 1'b1);
      frame(8'h12, 1'b0);
      rd_pulse(); rd_pulse();

      // R5 framing error and break
      cur_req = "R5";
      cfg_pmode = 2'b10; cfg_odd = 1'b0;
      send(8'h3C, 1'b0, 1'b0, 20, 0, -1);
      lit("R5", {4'b0, rx_status}, 8'h04);
      rd_pulse();
      send(8'h00, 1'b0, 1'b0, 32, 60, -1);
      lit("R5", {4'b0, rx_status}, 8'h0C);
      rd_pulse();

      // R6 disable mid-character keeps queue, re-enable resumes
      cur_req = "R6";
      frame(8'h11, 1'b0);
      send(8'h22, 1'b0, 1'b1, 32, 0, 4);
      lit("R6", rx_data, 8'h11);
      rd_pulse();
      frame(8'h33, 1'b0);
      cmd(0);
      frame(8'h44, 1'b0);
      lit("R6", rx_data, 8'h44);
      rd_pulse();

      // R7 overrun
      cur_req = "R7";
      frame(8'h01, 1'b0);
      frame(8'h02, 1'b0);
      frame(8'h03, 1'b0);
      frame(8'h04, 1'b0);
      lit("R7", {7'b0, rx_status[0]}, 8'h01);
      rd_pulse(); rd_pulse(); rd_pulse();

      // R9 empty read advances pointer, stale data shown
      cur_req = "R9";
      rd_pulse();
      frame(8'h55, 1'b0);
      lit("R9", {7'b0, rx_rdy}, 8'h01);

      // R8 reset realigns pointers
      cur_req = "R8";
      cmd(2);
      lit("R8", {7'b0, rx_rdy}, 8'h00);
      lit("R8", {4'b0, rx_status}, 8'h00);

      // R10 multidrop while disabled
      cur_req = "R10";
      cfg_pmode = 2'b11;
      cmd(1);
      frame(8'h10, 1'b0);
      lit("R10", {7'b0, rx_rdy}, 8'h00);
      frame(8'h20, 1'b1);
      lit("R10", {7'b0, rx_rdy}, 8'h01);
      lit("R10", {7'b0, rx_status[1]}, 8'h01);

      // R11 multidrop enabled keeps data characters
      cur_req = "R11";
      cmd(0);
      frame(8'h30, 1'b0);
      rd_pulse();
      lit("R11", rx_data, 8'h30);
      lit("R11", {7'b0, rx_status[1]}, 8'h00);
      rd_pulse();

      repeat (5) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule